// File: doc/BRIEF.md
# Low-Power Wake-Up Detector

This block watches for wake-up requests while a bus transceiver sits in one of its low-power modes. Two sources are recognised. A remote request arrives on the output of the low-power bus receiver: it has to show two dominant phases, each of a minimum length and each followed by a recessive phase of a minimum length. A local request is a level change on the WAKE input, in either direction, that then stays put for a debounce interval. All durations are counted in ticks of a slow time base supplied on `tick`, so the limits are parameters in ticks.

The block keeps a wake-up flag and a local-wake-up flag, and it drives the pull direction of the WAKE pin's bias current source so that the bias follows the debounced pin level. The surrounding mode controller supplies the operating mode, the power-up flag and a signal that is high while the undervoltage waiting time runs. The clear conditions are all handled here: power-up, undervoltage, entry to normal mode and exit from normal mode.

Top module: `lpw_wake_detector`

## Requirements
- R1: After reset, `wake_flag`, `local_flag` and `pull_up` are all 0, where `pull_up` 0 means pull-down.
- R2: In a low-power mode, a remote request sets `wake_flag`. The `mode` encoding is 0 normal, 1 receive-only, 2 standby, 3 go-to-sleep, 4 sleep, and the low-power modes are 2, 3 and 4. A remote request is a dominant phase of at least DOM_TICKS ticks, then a recessive phase of at least REC_TICKS, then a second dominant phase of at least DOM_TICKS, then a recessive phase that reaches REC_TICKS. `bus_dom` is 1 for dominant.
- R3: A dominant phase shorter than DOM_TICKS, or a first recessive phase shorter than REC_TICKS, returns the remote pattern to idle, so that the pattern as a whole does not set `wake_flag`.
- R4: In a low-power mode, a change of `wake_pin` from 0 to 1 or from 1 to 0 that then holds for at least DEB_TICKS ticks sets both `wake_flag` and `local_flag`.
- R5: A `wake_pin` pulse shorter than DEB_TICKS ticks changes none of the outputs.
- R6: `pull_up` takes the debounced `wake_pin` level (1 = pull-up, 0 = pull-down) in every mode. The first level debounced after reset only loads `pull_up` and is not a local wake-up.
- R7: In normal mode (0) and receive-only mode (1), neither remote nor local activity sets either flag.
- R8: While `uv_hold` is 1, `wake_flag` is cleared and cannot be set.
- R9: `local_flag` is set only while `pwrup_flag` is 0. A local request seen while `pwrup_flag` is 1 still sets `wake_flag`.
- R10: `wake_flag` is cleared one cycle after `pwrup_flag` rises and one cycle after `mode` changes to normal (0) from any other mode.
- R11: `local_flag` is cleared one cycle after `pwrup_flag` rises and one cycle after `mode` leaves normal (0). It stays set while the block is in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base enable; all durations count these pulses |
| bus_dom | input | 1 | Low-power receiver output, 1 = dominant |
| wake_pin | input | 1 | WAKE pin level |
| mode | input | 3 | Operating mode: 0 normal, 1 receive-only, 2 standby, 3 go-to-sleep, 4 sleep |
| pwrup_flag | input | 1 | Power-up flag from the mode controller |
| uv_hold | input | 1 | High while the undervoltage waiting time runs |
| wake_flag | output | 1 | Wake-up flag |
| local_flag | output | 1 | Local-wake-up flag |
| pull_up | output | 1 | WAKE bias direction: 1 pull-up, 0 pull-down |

## Verification
The bound checker enforces the flag rules on every cycle. A flag may rise only after a cycle in a low-power mode. The local flag may rise only while power-up is clear, and it must rise together with the wake flag unless blocked. The checker also confirms that undervoltage, power-up, entry to normal mode and exit from normal mode clear the right flags on the following cycle. The bench scenarios are the only place that shows the duration filtering itself: full, too-short-dominant and too-short-recessive bus patterns, debounced edges in both directions, a short glitch on WAKE, and a reset taken with WAKE high.

// File: rtl/lpw_pkg.sv
// Shared types for the low-power wake-up detector.
package lpw_pkg;

    typedef enum logic [2:0] {
        MODE_NORMAL  = 3'd0,
        MODE_RXONLY  = 3'd1,
        MODE_STANDBY = 3'd2,
        MODE_GOSLEEP = 3'd3,
        MODE_SLEEP   = 3'd4
    } op_mode_e;

    typedef enum logic [2:0] {
        RS_IDLE = 3'd0,
        RS_DOM1 = 3'd1,
        RS_REC1 = 3'd2,
        RS_DOM2 = 3'd3,
        RS_REC2 = 3'd4
    } rem_state_e;

    // True for the modes in which wake-up detection runs.
    function automatic logic is_low_power(input logic [2:0] m);
        return (m == MODE_STANDBY) || (m == MODE_GOSLEEP) || (m == MODE_SLEEP);
    endfunction

endpackage

// File: rtl/lpw_remote_filter.sv
// Remote wake-up pattern filter.
// Measures each dominant/recessive phase of the low-power receiver output
// in ticks. It needs dominant >= DOM_TICKS, recessive >= REC_TICKS,
// dominant >= DOM_TICKS, recessive >= REC_TICKS. Any phase that is too
// short returns the pattern to idle.
// Assumes bus_dom is already synchronous to clk. Held idle while disabled.
module lpw_remote_filter
    import lpw_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int DOM_TICKS = 10,
    parameter int REC_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    input  logic bus_dom,
    output logic hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] DOM_LIM = CNT_W'(DOM_TICKS);
    localparam logic [CNT_W-1:0] REC_LIM = CNT_W'(REC_TICKS);

    logic             lvl_q;
    logic [CNT_W-1:0] cnt_q;
    rem_state_e       st_q, st_d;
    logic             chg;

    assign chg = (bus_dom != lvl_q);
    assign hit = enable && (st_q == RS_REC2) && (cnt_q >= REC_LIM);

    // Phase length counter: restarts on every level change, saturates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            lvl_q <= bus_dom;
            if (chg)
                cnt_q <= '0;
            else if (tick && cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // Next pattern state: a phase is judged at the edge that ends it.
    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = RS_IDLE;
        end else begin
            case (st_q)
                RS_IDLE: if (chg && bus_dom) st_d = RS_DOM1;
                RS_DOM1: if (chg) st_d = (cnt_q >= DOM_LIM) ? RS_REC1 : RS_IDLE;
                RS_REC1: if (chg) st_d = (cnt_q >= REC_LIM) ? RS_DOM2 : RS_IDLE;
                RS_DOM2: if (chg) st_d = (cnt_q >= DOM_LIM) ? RS_REC2 : RS_IDLE;
                RS_REC2: if (hit || chg) st_d = RS_IDLE;
                default: st_d = RS_IDLE;
            endcase
        end
    end

    // Pattern state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RS_IDLE;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/lpw_pin_debounce.sv
// WAKE pin debouncer.
// A level is accepted once it has been steady for DEB_TICKS ticks. The
// accepted level drives the bias direction. A change of the accepted level
// gives a one-cycle event; the first level accepted after reset gives none.
// Assumes pin is already synchronous to clk.
module lpw_pin_debounce #(
    parameter int CNT_W     = 8,
    parameter int DEB_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic stable_lvl,
    output logic edge_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] DEB_LIM = CNT_W'(DEB_TICKS);

    logic             lvl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             stable_q;
    logic             primed_q;
    logic             accept;

    assign accept     = (cnt_q >= DEB_LIM) && ((lvl_q != stable_q) || !primed_q);
    assign edge_evt   = accept && primed_q;
    assign stable_lvl = stable_q;

    // Steadiness counter: restarts whenever the sampled pin level changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            lvl_q <= pin;
            if (pin != lvl_q)
                cnt_q <= '0;
            else if (tick && cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // Accepted level; starts as pull-down until the first level is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b0;
            primed_q <= 1'b0;
        end else if (accept) begin
            stable_q <= lvl_q;
            primed_q <= 1'b1;
        end
    end

endmodule

// File: rtl/lpw_flag_ctrl.sv
// Wake-up and local-wake-up flags.
// Sets the flags from detector events in low-power modes and applies the
// clear conditions; a clear wins over a set in the same cycle.
// Assumes mode and pwrup_flag are synchronous to clk.
module lpw_flag_ctrl
    import lpw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       pwrup_flag,
    input  logic       uv_hold,
    input  logic       remote_hit,
    input  logic       local_evt,
    output logic       wake_flag,
    output logic       local_flag
);
    logic [2:0] mode_q;
    logic       pwr_q;
    logic       lp;
    logic       pwr_rise, enter_norm, leave_norm;

    assign lp         = is_low_power(mode);
    assign pwr_rise   = pwrup_flag && !pwr_q;
    assign enter_norm = (mode == MODE_NORMAL) && (mode_q != MODE_NORMAL);
    assign leave_norm = (mode != MODE_NORMAL) && (mode_q == MODE_NORMAL);

    // Previous-cycle history for edge detection; follows inputs even in reset.
    always_ff @(posedge clk) begin
        mode_q <= mode;
        pwr_q  <= pwrup_flag;
    end

    // Wake-up flag: cleared by power-up, undervoltage or normal-mode entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wake_flag <= 1'b0;
        else if (pwr_rise || uv_hold || enter_norm)
            wake_flag <= 1'b0;
        else if (lp && (remote_hit || local_evt))
            wake_flag <= 1'b1;
    end

    // Local-wake-up flag: only while power-up is clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            local_flag <= 1'b0;
        else if (pwr_rise || leave_norm)
            local_flag <= 1'b0;
        else if (lp && local_evt && !pwrup_flag)
            local_flag <= 1'b1;
    end

endmodule

// File: rtl/lpw_wake_detector.sv
// Low-power wake-up detector top.
// Combines the remote pattern filter, the WAKE pin debouncer and the flag
// control. All durations are in ticks of the tick input.
// Assumes all inputs are synchronous to clk.
module lpw_wake_detector
    import lpw_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int DOM_TICKS = 10,
    parameter int REC_TICKS = 10,
    parameter int DEB_TICKS = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       bus_dom,
    input  logic       wake_pin,
    input  logic [2:0] mode,
    input  logic       pwrup_flag,
    input  logic       uv_hold,
    output logic       wake_flag,
    output logic       local_flag,
    output logic       pull_up
);
    logic remote_hit;
    logic local_evt;
    logic det_en;

    assign det_en = is_low_power(mode);

    lpw_remote_filter #(
        .CNT_W(CNT_W), .DOM_TICKS(DOM_TICKS), .REC_TICKS(REC_TICKS)
    ) u_remote (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(det_en),
        .bus_dom(bus_dom), .hit(remote_hit)
    );

    lpw_pin_debounce #(
        .CNT_W(CNT_W), .DEB_TICKS(DEB_TICKS)
    ) u_debounce (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pin(wake_pin),
        .stable_lvl(pull_up), .edge_evt(local_evt)
    );

    lpw_flag_ctrl u_flags (
        .clk(clk), .rst_n(rst_n), .mode(mode), .pwrup_flag(pwrup_flag),
        .uv_hold(uv_hold), .remote_hit(remote_hit), .local_evt(local_evt),
        .wake_flag(wake_flag), .local_flag(local_flag)
    );

endmodule

// File: rtl/lpw_wake_detector_chk.sv
// Protocol checker for the wake-up detector, bound to the top module.
module lpw_wake_detector_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       pwrup_flag,
    input logic       uv_hold,
    input logic       wake_flag,
    input logic       local_flag
);
    // R7
    wake_rise_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> ($past(mode) >= 3'd2 && $past(mode) <= 3'd4));

    // R7
    local_rise_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(local_flag) |-> ($past(mode) >= 3'd2 && $past(mode) <= 3'd4));

    // R8
    uv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_hold |=> !wake_flag);

    // R9
    local_pwrup_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(local_flag) |-> !$past(pwrup_flag));

    // R4
    local_with_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(local_flag) && !$past(uv_hold)) |-> wake_flag);

    // R10
    norm_entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && $past(mode) != 3'd0) |=> !wake_flag);

    // R10
    pwrup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwrup_flag) |=> (!wake_flag && !local_flag));

    // R11
    norm_exit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 3'd0 && $past(mode) == 3'd0) |=> !local_flag);

endmodule

bind lpw_wake_detector lpw_wake_detector_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pwrup_flag(pwrup_flag),
    .uv_hold(uv_hold), .wake_flag(wake_flag), .local_flag(local_flag)
);

// File: tb/lpw_wake_detector_tb.sv
`timescale 1ns/1ps
module lpw_wake_detector_tb;
    localparam int DOM_T = 4;
    localparam int REC_T = 4;
    localparam int DEB_T = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_dom = 1'b0;
    logic       wake_pin = 1'b0;
    logic [2:0] mode = 3'd2;
    logic       pwrup_flag = 1'b0;
    logic       uv_hold = 1'b0;
    logic       wake_flag, local_flag, pull_up;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int div = 0;

    always #4 clk = ~clk;

    // One tick every four clocks.
    always @(negedge clk) begin
        div  <= (div == 3) ? 0 : div + 1;
        tick <= (div == 3);
    end

    lpw_wake_detector #(
        .CNT_W(8), .DOM_TICKS(DOM_T), .REC_TICKS(REC_T), .DEB_TICKS(DEB_T)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_dom(bus_dom),
        .wake_pin(wake_pin), .mode(mode), .pwrup_flag(pwrup_flag),
        .uv_hold(uv_hold), .wake_flag(wake_flag), .local_flag(local_flag),
        .pull_up(pull_up)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wt(input int ticks);
        repeat (ticks * 4) @(negedge clk);
    endtask

    task automatic pattern(input int d1, input int r1, input int d2, input int r2);
        bus_dom = 1'b1; wt(d1);
        bus_dom = 1'b0; wt(r1);
        bus_dom = 1'b1; wt(d2);
        bus_dom = 1'b0; wt(r2);
    endtask

    // Pass through normal mode to clear flags and idle the pattern filter.
    task automatic settle();
        mode = 3'd0; wt(1);
        mode = 3'd2; wt(1);
    endtask

    task automatic do_reset(input logic pin);
        rst_n = 1'b0; wake_pin = pin; bus_dom = 1'b0; mode = 3'd2;
        pwrup_flag = 1'b0; uv_hold = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk("R1 wake_flag", wake_flag, 1'b0);
        chk("R1 local_flag", local_flag, 1'b0);
        chk("R1 pull_up", pull_up, 1'b0);
        wt(DEB_T + 4);
    endtask

    task automatic t_remote_ok();
        pattern(6, 6, 6, 6);
        chk("R2 remote sets wake_flag", wake_flag, 1'b1);
        chk("R2 remote leaves local_flag", local_flag, 1'b0);
        mode = 3'd0; wt(1);
        chk("R10 normal entry clears wake_flag", wake_flag, 1'b0);
        mode = 3'd4; wt(1);
        pattern(6, 6, 6, 6);
        chk("R2 remote in sleep", wake_flag, 1'b1);
        settle();
    endtask

    task automatic t_remote_short();
        pattern(2, 6, 6, 6);
        chk("R3 short dominant", wake_flag, 1'b0);
        settle();
        pattern(6, 2, 6, 6);
        chk("R3 short recessive", wake_flag, 1'b0);
        settle();
    endtask

    task automatic t_remote_active_modes();
        mode = 3'd0; wt(1);
        pattern(6, 6, 6, 6);
        chk("R7 remote in normal", wake_flag, 1'b0);
        mode = 3'd1; wt(1);
        pattern(6, 6, 6, 6);
        chk("R7 remote in receive-only", wake_flag, 1'b0);
        mode = 3'd2; wt(1);
    endtask

    task automatic t_local_edges();
        mode = 3'd3; wt(1);
        wake_pin = 1'b1; wt(DEB_T + 4);
        chk("R4 rise sets wake_flag", wake_flag, 1'b1);
        chk("R4 rise sets local_flag", local_flag, 1'b1);
        chk("R6 pull_up follows high", pull_up, 1'b1);
        mode = 3'd0; wt(1);
        chk("R10 normal entry clears wake", wake_flag, 1'b0);
        chk("R11 local held in normal", local_flag, 1'b1);
        mode = 3'd2; wt(1);
        chk("R11 normal exit clears local", local_flag, 1'b0);
        wake_pin = 1'b0; wt(DEB_T + 4);
        chk("R4 fall sets wake_flag", wake_flag, 1'b1);
        chk("R4 fall sets local_flag", local_flag, 1'b1);
        chk("R6 pull_up follows low", pull_up, 1'b0);
        settle();
    endtask

    task automatic t_glitch();
        wake_pin = 1'b1; wt(DEB_T / 2);
        wake_pin = 1'b0; wt(DEB_T + 4);
        chk("R5 glitch wake_flag", wake_flag, 1'b0);
        chk("R5 glitch local_flag", local_flag, 1'b0);
        chk("R5 glitch pull_up", pull_up, 1'b0);
    endtask

    task automatic t_local_normal();
        mode = 3'd0; wt(1);
        wake_pin = 1'b1; wt(DEB_T + 4);
        chk("R6 pull_up in normal", pull_up, 1'b1);
        chk("R7 local in normal wake", wake_flag, 1'b0);
        chk("R7 local in normal local", local_flag, 1'b0);
        wake_pin = 1'b0; wt(DEB_T + 4);
        chk("R6 pull_up back low in normal", pull_up, 1'b0);
        mode = 3'd2; wt(1);
    endtask

    task automatic t_uv();
        uv_hold = 1'b1;
        pattern(6, 6, 6, 6);
        chk("R8 set blocked", wake_flag, 1'b0);
        uv_hold = 1'b0; wt(1);
        pattern(6, 6, 6, 6);
        chk("R8 set after hold", wake_flag, 1'b1);
        uv_hold = 1'b1; @(negedge clk); @(negedge clk);
        chk("R8 hold clears", wake_flag, 1'b0);
        uv_hold = 1'b0;
        settle();
    endtask

    task automatic t_pwrup();
        wake_pin = 1'b1; wt(DEB_T + 4);
        chk("R4 local before power-up", local_flag, 1'b1);
        pwrup_flag = 1'b1; @(negedge clk); @(negedge clk);
        chk("R10 power-up clears wake", wake_flag, 1'b0);
        chk("R11 power-up clears local", local_flag, 1'b0);
        wake_pin = 1'b0; wt(DEB_T + 4);
        chk("R9 wake set under power-up", wake_flag, 1'b1);
        chk("R9 local blocked under power-up", local_flag, 1'b0);
        pwrup_flag = 1'b0;
        settle();
    endtask

    task automatic t_reset_high();
        do_reset(1'b1);
        wt(DEB_T + 4);
        chk("R6 first level loads pull_up", pull_up, 1'b1);
        chk("R6 first level no wake", wake_flag, 1'b0);
        chk("R6 first level no local", local_flag, 1'b0);
    endtask

    initial begin
        t_reset();
        t_remote_ok();
        t_remote_short();
        t_remote_active_modes();
        t_local_edges();
        t_glitch();
        t_local_normal();
        t_uv();
        t_pwrup();
        t_reset_high();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule